// File: doc/BRIEF.md
# Serial Flash Status Register with Write Protection

This block is the status-register slice of a serial-flash slave. It oversamples chip select, serial clock and serial data with the system clock and accepts either SPI clock polarity (mode 0 or mode 3). It decodes three commands:

- Set the write latch (opcode 0x06).
- Read the status byte (opcode 0x05).
- Write the status byte (opcode 0x01 followed by one data byte).

It keeps an eight-bit status byte and returns it on MISO. It also drives the three-bit block-protect field on a dedicated output for the array logic.

A status write is a guarded operation. It needs the write latch to have been set by an earlier frame. The frame must end on an exact byte boundary. The combination of the write-disable bit and the write-protect pin must not lock the register. An accepted write starts a self-timed busy window of a programmable number of system clocks. When the window ends, the in-progress flag and the write latch both clear.

The serial clock is assumed to run well below the system clock, with each SCLK half period lasting at least four system clocks.

Top module: `spi_status_wp`

## Requirements
- R1: Opcode 0x06 sets the write latch (status bit 1) only when chip select rises after exactly 8 clocked bits. A frame of 7 or 9 bits leaves the latch unchanged.
- R2: Opcode 0x05 returns the status byte on MISO, MSB first, changing after falling SCLK edges, in both mode 0 and mode 3. The byte repeats for as long as chip select stays low. The status layout is as follows:
  - Bit 7 is the write-disable flag.
  - Bits 4..2 are the block-protect field.
  - Bit 1 is the write latch.
  - Bit 0 is the in-progress flag.
  - Bits 6 and 5 read 0.
- R3: An accepted opcode 0x01 write loads only two parts of the status byte. Data bit 7 goes to the write-disable flag and data bits 4..2 go to the block-protect field. Data bits 6, 5, 1 and 0 have no effect.
- R4: Opcode 0x01 with the write latch clear is not executed, and the status byte is unchanged.
- R5: Opcode 0x01 is not executed unless chip select rises after exactly 16 bits. Frames of 15, 17 or 24 bits leave the status unchanged, and the write latch stays set.
- R6: An accepted write sets the in-progress flag from the rise of chip select for WR_CYCLES system clocks. During that time the flag reads 1 through opcode 0x05. At the end of the window the flag and the write latch both read 0.
- R7: While the write-disable flag is 1 and the write-protect pin is low, every status write is rejected even with the latch set. This holds in whichever order the two conditions arose. Driving the pin high makes writes possible again.
- R8: With the write-disable flag at 0, a status write is accepted even when the write-protect pin is low.
- R9: While the in-progress flag is 1, opcodes 0x06 and 0x01 are ignored and opcode 0x05 is still served.
- R10: The output bp_out always equals status bits 4..2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, mode 0 or mode 3 |
| mosi | input | 1 | Serial data in, sampled on rising SCLK |
| wp_n | input | 1 | Write-protect pin, active low |
| miso | output | 1 | Serial data out; drives 0 when no status is being read |
| bp_out | output | 3 | Current block-protect field |

## Verification
The bench ends frames one bit short of a byte boundary, one bit past it, and one whole byte past it, and expects no status change. A design that counted bytes loosely would take the write and drop the write latch.

It walks all sixteen combinations of the writable bits against two opposite patterns in the ignored bits. A design that leaked a data bit into bits 6, 5, 1 or 0 would read back a wrong byte.

It enters the locked state in both orders (pin first, then flag, and flag first, then pin), then releases the pin. It also issues writes and latch commands inside the busy window and polls the in-progress flag there. A design that missed either the lock or the busy guard would either change the protect field or keep the latch set after the window ends.

// File: rtl/spi_sr_pkg.sv
// Package: command codes and status bit positions shared by the status block.
// Assumes one status byte of eight bits; positions are fixed by the read-back layout.
package spi_sr_pkg;
    localparam int BYTE_W = 8;
    localparam logic [7:0] OP_SET_LATCH  = 8'h06;
    localparam logic [7:0] OP_READ_STAT  = 8'h05;
    localparam logic [7:0] OP_WRITE_STAT = 8'h01;
    localparam int SB_LOCK   = 7;
    localparam int SB_BP_HI  = 4;
    localparam int SB_BP_LO  = 2;
    localparam int SB_LATCH  = 1;
    localparam int SB_BUSY   = 0;
    localparam int BP_W      = SB_BP_HI - SB_BP_LO + 1;
endpackage

// File: rtl/spi_sr_sync.sv
// Module: multi-stage synchronizer bank for asynchronous pins.
// Assumes STAGES >= 2; each bit resets to its own RST_VAL bit.
module spi_sr_sync #(
    parameter int W = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] ff;
        // Shift the pin value through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) ff <= {STAGES{RST_VAL[g]}};
            else        ff <= {ff[STAGES-2:0], d_in[g]};
        end
        assign q_out[g] = ff[STAGES-1];
    end
endmodule

// File: rtl/spi_sr_frame.sv
// Module: SPI frame engine. Detects edges on synchronized pins, assembles bytes
// on rising SCLK, counts whole bytes, and shifts the status byte out on falling
// SCLK once a read command has been received.
// Assumes inputs already synchronized and SCLK half period >= 4 system clocks.
module spi_sr_frame
    import spi_sr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_s,
    input  logic             sclk_s,
    input  logic             mosi_s,
    input  logic [BYTE_W-1:0] status_in,
    output logic             frame_end,
    output logic [BYTE_W-1:0] opcode,
    output logic [BYTE_W-1:0] data_byte,
    output logic [1:0]       nbytes,
    output logic             aligned,
    output logic             miso
);
    localparam int BC_W = $clog2(BYTE_W);

    logic              cs_d, sclk_d;
    logic              sclk_rise, sclk_fall;
    logic [BC_W-1:0]   bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] next_byte;
    logic              rd_active;
    logic [BC_W-1:0]   out_idx;
    logic [BYTE_W-1:0] tx_snap;
    logic              miso_q;

    assign sclk_rise = !cs_s &&  sclk_s && !sclk_d;
    assign sclk_fall = !cs_s && !sclk_s &&  sclk_d;
    assign frame_end =  cs_s && !cs_d;
    assign next_byte = {shreg[BYTE_W-2:0], mosi_s};
    assign aligned   = (bit_cnt == '0);
    assign miso      = miso_q;

    // Delayed copies of the pins for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d   <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            cs_d   <= cs_s;
            sclk_d <= sclk_s;
        end
    end

    // Input side: bit counter, byte assembly, byte count, read detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            nbytes    <= '0;
            opcode    <= '0;
            data_byte <= '0;
            rd_active <= 1'b0;
        end else if (cs_s) begin
            bit_cnt   <= '0;
            nbytes    <= '0;
            rd_active <= 1'b0;
        end else if (sclk_rise) begin
            shreg   <= next_byte;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == BC_W'(BYTE_W - 1)) begin
                if (nbytes != 2'd3) nbytes <= nbytes + 2'd1;
                if (nbytes == 2'd0) begin
                    opcode <= next_byte;
                    if (next_byte == OP_READ_STAT) rd_active <= 1'b1;
                end
                if (nbytes == 2'd1) data_byte <= next_byte;
            end
        end
    end

    // Output side: snapshot status at each byte start, present one bit per falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_idx <= BC_W'(BYTE_W - 1);
            tx_snap <= '0;
            miso_q  <= 1'b0;
        end else if (cs_s) begin
            out_idx <= BC_W'(BYTE_W - 1);
            miso_q  <= 1'b0;
        end else if (sclk_fall && rd_active) begin
            if (out_idx == BC_W'(BYTE_W - 1)) begin
                tx_snap <= status_in;
                miso_q  <= status_in[BYTE_W-1];
            end else begin
                miso_q  <= tx_snap[out_idx];
            end
            out_idx <= out_idx - 1'b1;
        end
    end
endmodule

// File: rtl/spi_sr_regs.sv
// Module: status register, protection gating and self-timed write window.
// Commands are judged at the end of a frame using the byte count and alignment.
// Assumes WR_CYCLES >= 1; wp_s is already synchronized.
module spi_sr_regs
    import spi_sr_pkg::*;
#(
    parameter int WR_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_end,
    input  logic [BYTE_W-1:0] opcode,
    input  logic [BYTE_W-1:0] data_byte,
    input  logic [1:0]        nbytes,
    input  logic              aligned,
    input  logic              wp_s,
    output logic [BYTE_W-1:0] status,
    output logic [BP_W-1:0]   bp
);
    localparam int CW = $clog2(WR_CYCLES + 1);

    logic          lock_bit, latch, busy;
    logic [CW-1:0] cnt;
    logic          hw_locked, do_latch, do_write;
    logic          unused_data;

    assign unused_data = ^{data_byte[6:5], data_byte[1:0]};
    assign hw_locked   = lock_bit && !wp_s;
    assign do_latch    = frame_end && aligned && (nbytes == 2'd1)
                         && (opcode == OP_SET_LATCH) && !busy;
    assign do_write    = frame_end && aligned && (nbytes == 2'd2)
                         && (opcode == OP_WRITE_STAT) && !busy && latch && !hw_locked;

    // Assemble the visible status byte.
    always_comb begin
        status           = '0;
        status[SB_LOCK]  = lock_bit;
        status[SB_BP_HI:SB_BP_LO] = bp;
        status[SB_LATCH] = latch;
        status[SB_BUSY]  = busy;
    end

    // Update configuration, latch and busy window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_bit <= 1'b0;
            bp       <= '0;
            latch    <= 1'b0;
            busy     <= 1'b0;
            cnt      <= '0;
        end else if (do_write) begin
            lock_bit <= data_byte[SB_LOCK];
            bp       <= data_byte[SB_BP_HI:SB_BP_LO];
            busy     <= 1'b1;
            cnt      <= CW'(WR_CYCLES - 1);
        end else if (busy) begin
            if (cnt == '0) begin
                busy  <= 1'b0;
                latch <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end else if (do_latch) begin
            latch <= 1'b1;
        end
    end
endmodule

// File: rtl/spi_status_wp.sv
// Module: top of the status-register slice. Synchronizes the pins, runs the
// frame engine and the protected status register, and exports the protect field.
// Assumes SCLK far slower than clk; MISO is driven low when not reading.
module spi_status_wp
    import spi_sr_pkg::*;
#(
    parameter int WR_CYCLES = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            sclk,
    input  logic            mosi,
    input  logic            wp_n,
    output logic            miso,
    output logic [BP_W-1:0] bp_out
);
    logic              cs_s, sclk_s, mosi_s, wp_s;
    logic              frame_end, aligned;
    logic [BYTE_W-1:0] opcode, data_byte, status;
    logic [1:0]        nbytes;

    spi_sr_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) i_sync (
        .clk(clk), .rst_n(rst_n),
        .d_in({cs_n, sclk, mosi, wp_n}),
        .q_out({cs_s, sclk_s, mosi_s, wp_s})
    );

    spi_sr_frame i_frame (
        .clk(clk), .rst_n(rst_n),
        .cs_s(cs_s), .sclk_s(sclk_s), .mosi_s(mosi_s),
        .status_in(status),
        .frame_end(frame_end), .opcode(opcode), .data_byte(data_byte),
        .nbytes(nbytes), .aligned(aligned), .miso(miso)
    );

    spi_sr_regs #(.WR_CYCLES(WR_CYCLES)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .frame_end(frame_end), .opcode(opcode), .data_byte(data_byte),
        .nbytes(nbytes), .aligned(aligned), .wp_s(wp_s),
        .status(status), .bp(bp_out)
    );
endmodule

// File: rtl/spi_sr_checker.sv
// Module: protocol checks on the status slice, bound into the top module.
// Assumes the status byte layout from spi_sr_pkg.
module spi_sr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_end,
    input logic [7:0] status,
    input logic       wp_s
);
    AST_BUSY_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] |-> status[1]); // R6
    AST_BUSY_STARTS_AT_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> $past(frame_end)); // R6
    AST_LATCH_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> !status[1]); // R6
    AST_CFG_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({status[7], status[4:2]}) |->
            ($past(status[1]) && $past(frame_end) && !$past(status[0]))); // R4
    AST_HW_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && status[7] && !wp_s) |=> $stable({status[7], status[4:2]})); // R7
endmodule

bind spi_status_wp spi_sr_checker i_chk (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .status(status), .wp_s(wp_s)
);

// File: tb/test_spi_status_wp.sv
module test_spi_status_wp;
    localparam int WR   = 900;
    localparam int HALF = 6;

    logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, mosi = 0, wp_n = 1;
    logic miso;
    logic [2:0] bp_out;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    spi_status_wp #(.WR_CYCLES(WR)) i_spi_status_wp (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .wp_n(wp_n), .miso(miso), .bp_out(bp_out)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    task automatic xfer(input bit m3, input logic [31:0] txd, input int nbits,
                        output logic [31:0] rxd);
        rxd = '0;
        sclk = m3;
        wait_clk(HALF);
        cs_n = 0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            sclk = 0;
            mosi = txd[31-i];
            wait_clk(HALF);
            rxd = {rxd[30:0], miso};
            sclk = 1;
            wait_clk(HALF);
        end
        if (!m3) begin
            sclk = 0;
            wait_clk(HALF);
        end
        cs_n = 1;
        wait_clk(2 * HALF);
    endtask

    task automatic set_latch(input bit m3, input int nbits);
        logic [31:0] rx;
        xfer(m3, {8'h06, 24'h0}, nbits, rx);
    endtask

    task automatic write_sr(input bit m3, input logic [7:0] d, input int nbits);
        logic [31:0] rx;
        xfer(m3, {8'h01, d, 16'h0}, nbits, rx);
    endtask

    task automatic read_sr(input bit m3, output logic [7:0] b);
        logic [31:0] rx;
        xfer(m3, {8'h05, 24'h0}, 16, rx);
        b = rx[7:0];
    endtask

    initial begin
        repeat (250000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [7:0] b;
        logic [31:0] rx;
        wait_clk(5);
        rst_n = 1;
        wait_clk(5);

        read_sr(0, b); check("R2 reset status", b, 8'h00);
        check("R10 reset bp_out", {5'd0, bp_out}, 8'h00);

        set_latch(0, 7); read_sr(0, b); check("R1 latch 7 bits", b, 8'h00);
        set_latch(1, 9); read_sr(0, b); check("R1 latch 9 bits", b, 8'h00);
        set_latch(1, 8); read_sr(1, b); check("R1 latch set", b, 8'h02);

        xfer(0, {8'h05, 24'h0}, 24, rx);
        check("R2 repeat byte1", rx[15:8], 8'h02);
        check("R2 repeat byte2", rx[7:0], 8'h02);

        write_sr(0, 8'h9C, 15); read_sr(0, b); check("R5 15 bits", b, 8'h02);
        write_sr(1, 8'h9C, 17); read_sr(0, b); check("R5 17 bits", b, 8'h02);
        write_sr(0, 8'h9C, 24); read_sr(1, b); check("R5 24 bits", b, 8'h02);

        write_sr(0, 8'hFF, 16);
        read_sr(1, b); check("R6 busy polled", b, 8'h9F);
        write_sr(0, 8'h00, 16);
        wait_clk(WR + 20);
        read_sr(0, b); check("R9 write during busy ignored, R6 end", b, 8'h9C);
        check("R10 bp_out after write", {5'd0, bp_out}, 8'h07);

        write_sr(1, 8'h00, 16); read_sr(0, b); check("R4 no latch", b, 8'h9C);

        set_latch(0, 8); write_sr(0, 8'h9C, 16); set_latch(0, 8);
        wait_clk(WR + 20);
        read_sr(0, b); check("R9 latch during busy ignored", b, 8'h9C);

        wp_n = 0; wait_clk(10);
        set_latch(0, 8); write_sr(0, 8'h00, 16); wait_clk(WR + 20);
        read_sr(0, b); check("R7 flag then pin locked", b, 8'h9E);
        wp_n = 1; wait_clk(10);
        write_sr(1, 8'h00, 16); wait_clk(WR + 20);
        read_sr(0, b); check("R7 pin released", b, 8'h00);

        wp_n = 0; wait_clk(10);
        set_latch(0, 8); write_sr(0, 8'h90, 16); wait_clk(WR + 20);
        read_sr(1, b); check("R8 unlocked with pin low", b, 8'h90);
        check("R10 bp_out field", {5'd0, bp_out}, 8'h04);
        set_latch(0, 8); write_sr(0, 8'h00, 16); wait_clk(WR + 20);
        read_sr(0, b); check("R7 pin then flag locked", b, 8'h92);
        wp_n = 1; wait_clk(10);
        write_sr(0, 8'h00, 16); wait_clk(WR + 20);
        read_sr(0, b); check("R7 release second order", b, 8'h00);

        for (int v = 0; v < 32; v++) begin
            logic [3:0] cfg, ign;
            logic [7:0] d;
            bit m3;
            cfg = v[3:0];
            ign = v[4] ? 4'b1011 : 4'b0100;
            d = {cfg[3], ign[3:2], cfg[2:0], ign[1:0]};
            m3 = v[0] ^ v[4];
            set_latch(m3, 8);
            write_sr(m3, d, 16);
            wait_clk(WR + 20);
            read_sr(!m3, b);
            check("R3 sweep status", b, {cfg[3], 2'b00, cfg[2:0], 2'b00});
            check("R10 sweep bp_out", {5'd0, bp_out}, {5'd0, cfg[2:0]});
        end

        done = 1;
        finish_run();
    end
endmodule